// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block decides which clocks and oscillator resources are running. Software selects one of six operating levels: full activity or one of five progressively deeper sleep levels. From that level the block drives enables for the CPU main clock, the peripheral sub-clock and the auxiliary clock. It also drives an enable for the oscillator's DC generator, an enable for the crystal oscillator, and a halt indication for the CPU.

An interrupt wakes the block to full activity and keeps the sleep level it left in a single save slot. The interrupt-return pulse puts that level back. Nested interrupts are not supported. While an interrupt is in service, a mode write goes to the save slot, so the handler can choose the level to return to. After power-up the block looks at the first fetched reset vector. If that vector is all ones, meaning nothing is programmed, the block goes straight to the deepest sleep level.

Every clock and oscillator enable comes from its own register. An enable therefore changes only at a clock edge, one cycle after the mode register changes, and no gated clock pulse is cut short.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After synchronous reset, pm_mode is 0 and in_service is 0. mclk_en, smclk_en, aclk_en, dcgen_en and xosc_en are all 1, and cpu_halt is 0.
- R2: A mode_wr pulse with mode_req in 0..5 (0 = active, 1..5 = sleep levels 0..4) loads pm_mode at the next edge, provided no interrupt is in service. The enables and cpu_halt follow one edge after pm_mode.
- R3: A mode_wr pulse with mode_req equal to 6 or 7 leaves pm_mode and every enable unchanged.
- R4: In mode 0 every enable is 1 and cpu_halt is 0. In mode 1 mclk_en is 0, cpu_halt is 1, and the other enables are 1.
- R5: In mode 2 the enables match mode 1, except that dcgen_en equals dco_feeds_main.
- R6: In mode 3 mclk_en and smclk_en are 0, while aclk_en, dcgen_en and xosc_en are 1. cpu_halt is 1.
- R7: In mode 4 only aclk_en and xosc_en are 1. cpu_halt is 1.
- R8: In mode 5 every enable is 0, including xosc_en, and cpu_halt is 1.
- R9: An irq pulse while in_service is 0 saves the current mode. pm_mode becomes 0 and in_service becomes 1 at the next edge. A mode_wr in the same cycle is dropped.
- R10: An irq_ret pulse while in_service is 1 restores the saved mode and clears in_service at the next edge. An irq_ret pulse while in_service is 0 has no effect.
- R11: While in_service is 1, a further irq has no effect and pm_mode stays 0. A mode_wr with a valid code replaces the saved mode.
- R12: The first boot_valid pulse after reset with boot_vec all ones sets pm_mode to 5. Any other vector leaves the mode unchanged. Later boot_valid pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Strobe that latches mode_req |
| mode_req | input | 3 | Requested mode code |
| dco_feeds_main | input | 1 | DCO is the active-mode main clock source |
| irq | input | 1 | Interrupt request pulse |
| irq_ret | input | 1 | Interrupt return pulse |
| boot_valid | input | 1 | Reset vector fetch complete |
| boot_vec | input | VEC_W | Fetched reset vector |
| pm_mode | output | 3 | Current mode code |
| in_service | output | 1 | Interrupt being serviced |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Peripheral sub-clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dcgen_en | output | 1 | DC generator enable |
| xosc_en | output | 1 | Crystal oscillator enable |
| cpu_halt | output | 1 | CPU halted |

## Verification
A table walk sends each mode code through the block in sequence. The codes go from light to deep sleep, then back to active. The two invalid codes are placed between valid ones, so a wrong update shows up as a changed mode. Mode 2 is written twice, once with the DCO selected as the main source and once without, and only the DC generator enable should differ between the two. Directed sequences follow. They wake the block from a deep level and try a nested interrupt. They redirect the saved mode inside the handler, send a return with no interrupt in service, and send an interrupt in the same cycle as a mode write. The last sequences boot the block with a blank reset vector, with a programmed vector, and with a second vector that should be ignored.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

    localparam int PM_MODE_W = 3;
    localparam int PM_GATE_N = 6;

    typedef enum logic [PM_MODE_W-1:0] {
        PM_RUN    = 3'd0,
        PM_SLEEP0 = 3'd1,
        PM_SLEEP1 = 3'd2,
        PM_SLEEP2 = 3'd3,
        PM_SLEEP3 = 3'd4,
        PM_SLEEP4 = 3'd5
    } pm_mode_t;

    typedef struct packed {
        logic mclk;
        logic smclk;
        logic aclk;
        logic dcgen;
        logic xosc;
        logic halt;
    } pm_gate_t;

    localparam pm_gate_t PM_GATE_RESET = '{mclk: 1'b1, smclk: 1'b1, aclk: 1'b1,
                                           dcgen: 1'b1, xosc: 1'b1, halt: 1'b0};

    function automatic logic pm_code_ok(input logic [PM_MODE_W-1:0] code);
        return code <= PM_SLEEP4;
    endfunction

    function automatic pm_gate_t pm_decode(input pm_mode_t m, input logic dco_main);
        pm_gate_t g;
        g = PM_GATE_RESET;
        unique case (m)
            PM_RUN: g = PM_GATE_RESET;
            PM_SLEEP0: begin
                g.mclk = 1'b0;
                g.halt = 1'b1;
            end
            PM_SLEEP1: begin
                g.mclk  = 1'b0;
                g.halt  = 1'b1;
                g.dcgen = dco_main;
            end
            PM_SLEEP2: begin
                g.mclk  = 1'b0;
                g.smclk = 1'b0;
                g.halt  = 1'b1;
            end
            PM_SLEEP3: begin
                g.mclk  = 1'b0;
                g.smclk = 1'b0;
                g.dcgen = 1'b0;
                g.halt  = 1'b1;
            end
            PM_SLEEP4: begin
                g = '0;
                g.halt = 1'b1;
            end
            default: g = PM_GATE_RESET;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pm_seq.sv
module pm_seq
    import pwrmode_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_wr,
    input  logic [PM_MODE_W-1:0] mode_req,
    input  logic                 irq,
    input  logic                 irq_ret,
    input  logic                 boot_valid,
    input  logic [VEC_W-1:0]     boot_vec,
    output pm_mode_t             mode_q,
    output logic                 busy_q
);
    localparam logic [VEC_W-1:0] BLANK_VEC = {VEC_W{1'b1}};

    pm_mode_t save_q;
    logic     boot_seen_q;
    logic     wr_ok;
    logic     boot_blank;

    assign wr_ok      = mode_wr && pm_code_ok(mode_req);
    assign boot_blank = boot_valid && !boot_seen_q && (boot_vec == BLANK_VEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= PM_RUN;
            save_q      <= PM_RUN;
            busy_q      <= 1'b0;
            boot_seen_q <= 1'b0;
        end else begin
            if (irq && !busy_q) begin
                save_q <= mode_q;
                mode_q <= PM_RUN;
                busy_q <= 1'b1;
            end else if (irq_ret && busy_q) begin
                mode_q <= save_q;
                busy_q <= 1'b0;
            end else if (boot_blank && !busy_q) begin
                mode_q <= PM_SLEEP4;
            end else if (wr_ok) begin
                if (busy_q) begin
                    save_q <= pm_mode_t'(mode_req);
                end else begin
                    mode_q <= pm_mode_t'(mode_req);
                end
            end
            if (boot_valid) begin
                boot_seen_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pm_map.sv
module pm_map
    import pwrmode_pkg::*;
(
    input  pm_mode_t mode,
    input  logic     dco_main,
    output pm_gate_t gate
);
    always_comb begin
        gate = pm_decode(mode, dco_main);
    end
endmodule

// File: rtl/pm_gate_reg.sv
module pm_gate_reg #(
    parameter int                 N        = 6,
    parameter logic [N-1:0]       RST_VAL  = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= RST_VAL[i];
            end else begin
                q[i] <= d[i];
            end
        end
    end
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
    import pwrmode_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_wr,
    input  logic [2:0]           mode_req,
    input  logic                 dco_feeds_main,
    input  logic                 irq,
    input  logic                 irq_ret,
    input  logic                 boot_valid,
    input  logic [VEC_W-1:0]     boot_vec,
    output logic [2:0]           pm_mode,
    output logic                 in_service,
    output logic                 mclk_en,
    output logic                 smclk_en,
    output logic                 aclk_en,
    output logic                 dcgen_en,
    output logic                 xosc_en,
    output logic                 cpu_halt
);
    pm_mode_t mode_q;
    logic     busy_q;
    pm_gate_t gate_d;
    pm_gate_t gate_q;
    logic [PM_GATE_N-1:0] gate_vec_q;

    pm_seq #(.VEC_W(VEC_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (mode_wr),
        .mode_req   (mode_req),
        .irq        (irq),
        .irq_ret    (irq_ret),
        .boot_valid (boot_valid),
        .boot_vec   (boot_vec),
        .mode_q     (mode_q),
        .busy_q     (busy_q)
    );

    pm_map u_map (
        .mode     (mode_q),
        .dco_main (dco_feeds_main),
        .gate     (gate_d)
    );

    pm_gate_reg #(.N(PM_GATE_N), .RST_VAL(PM_GATE_RESET)) u_gate (
        .clk (clk),
        .rst (rst),
        .d   (gate_d),
        .q   (gate_vec_q)
    );

    assign gate_q     = pm_gate_t'(gate_vec_q);
    assign pm_mode    = mode_q;
    assign in_service = busy_q;
    assign mclk_en    = gate_q.mclk;
    assign smclk_en   = gate_q.smclk;
    assign aclk_en    = gate_q.aclk;
    assign dcgen_en   = gate_q.dcgen;
    assign xosc_en    = gate_q.xosc;
    assign cpu_halt   = gate_q.halt;
endmodule

// File: rtl/pwrmode_chk.sv
module pwrmode_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_wr,
    input logic [2:0] mode_req,
    input logic       dco_feeds_main,
    input logic       irq,
    input logic       irq_ret,
    input logic       boot_valid,
    input logic [2:0] pm_mode,
    input logic       in_service,
    input logic       mclk_en,
    input logic       smclk_en,
    input logic       aclk_en,
    input logic       dcgen_en,
    input logic       xosc_en,
    input logic       cpu_halt
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pm_mode == 3'd0 && !in_service));

    // R3
    a_r3_bad_code_ignored: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_req > 3'd5 && !irq && !irq_ret && !boot_valid && !in_service)
        |=> $stable(pm_mode));

    // R5
    a_r5_dcgen_follows_source: assert property (@(posedge clk) disable iff (rst)
        (pm_mode == 3'd2) |=> (dcgen_en == $past(dco_feeds_main) && !mclk_en && smclk_en));

    // R7
    a_r7_aux_only: assert property (@(posedge clk) disable iff (rst)
        (pm_mode == 3'd4) |=> (!mclk_en && !smclk_en && aclk_en && !dcgen_en && xosc_en && cpu_halt));

    // R8
    a_r8_all_off: assert property (@(posedge clk) disable iff (rst)
        (pm_mode == 3'd5) |=> (!mclk_en && !smclk_en && !aclk_en && !dcgen_en && !xosc_en && cpu_halt));

    // R9
    a_r9_wake: assert property (@(posedge clk) disable iff (rst)
        (irq && !in_service) |=> (pm_mode == 3'd0 && in_service));

    // R10
    a_r10_return: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && in_service) |=> !in_service);

    // R11
    a_r11_no_nesting: assert property (@(posedge clk) disable iff (rst)
        (in_service && !irq_ret) |=> (pm_mode == 3'd0 && in_service));
endmodule

bind pwrmode_ctrl pwrmode_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .mode_wr        (mode_wr),
    .mode_req       (mode_req),
    .dco_feeds_main (dco_feeds_main),
    .irq            (irq),
    .irq_ret        (irq_ret),
    .boot_valid     (boot_valid),
    .pm_mode        (pm_mode),
    .in_service     (in_service),
    .mclk_en        (mclk_en),
    .smclk_en       (smclk_en),
    .aclk_en        (aclk_en),
    .dcgen_en       (dcgen_en),
    .xosc_en        (xosc_en),
    .cpu_halt       (cpu_halt)
);

// File: tb/sim_pwrmode_ctrl.sv
module sim_pwrmode_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_req = 3'd0;
    logic        dco_feeds_main = 1'b1;
    logic        irq = 1'b0;
    logic        irq_ret = 1'b0;
    logic        boot_valid = 1'b0;
    logic [15:0] boot_vec = 16'h0000;
    logic [2:0]  pm_mode;
    logic        in_service;
    logic        mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en, cpu_halt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwrmode_ctrl u0 (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_req(mode_req),
        .dco_feeds_main(dco_feeds_main), .irq(irq), .irq_ret(irq_ret),
        .boot_valid(boot_valid), .boot_vec(boot_vec), .pm_mode(pm_mode),
        .in_service(in_service), .mclk_en(mclk_en), .smclk_en(smclk_en),
        .aclk_en(aclk_en), .dcgen_en(dcgen_en), .xosc_en(xosc_en), .cpu_halt(cpu_halt)
    );

    // {mode_req, dco, expected mode, expected gates m,s,a,d,x,h}
    localparam logic [12:0] VEC [9] = '{
        {3'd1, 1'b1, 3'd1, 6'b011111},  // R4
        {3'd2, 1'b1, 3'd2, 6'b011111},  // R5
        {3'd2, 1'b0, 3'd2, 6'b011011},  // R5
        {3'd3, 1'b0, 3'd3, 6'b001111},  // R6
        {3'd4, 1'b0, 3'd4, 6'b001011},  // R7
        {3'd6, 1'b0, 3'd4, 6'b001011},  // R3
        {3'd5, 1'b0, 3'd5, 6'b000001},  // R8
        {3'd7, 1'b0, 3'd5, 6'b000001},  // R3
        {3'd0, 1'b1, 3'd0, 6'b111110}   // R2 R4
    };

    function automatic logic [5:0] gates();
        return {mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en, cpu_halt};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_mode(input logic [2:0] code);
        @(negedge clk);
        mode_wr = 1'b1;
        mode_req = code;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    task automatic pulse_ret();
        @(negedge clk);
        irq_ret = 1'b1;
        @(negedge clk);
        irq_ret = 1'b0;
    endtask

    task automatic boot(input logic [15:0] v);
        @(negedge clk);
        boot_valid = 1'b1;
        boot_vec = v;
        @(negedge clk);
        boot_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 mode", 16'(pm_mode), 16'd0);
        check("R1 service", 16'(in_service), 16'd0);
        check("R1 gates", 16'(gates()), 16'b111110);

        for (int i = 0; i < 9; i++) begin
            dco_feeds_main = VEC[i][9];
            write_mode(VEC[i][12:10]);
            check($sformatf("R2 table %0d mode", i), 16'(pm_mode), 16'(VEC[i][8:6]));
            @(negedge clk);
            check($sformatf("R2 table %0d gates", i), 16'(gates()), 16'(VEC[i][5:0]));
        end

        // R9: wake from sleep level 3
        write_mode(3'd4);
        @(negedge clk);
        pulse_irq();
        check("R9 wake mode", 16'(pm_mode), 16'd0);
        check("R9 wake service", 16'(in_service), 16'd1);
        @(negedge clk);
        check("R9 wake gates", 16'(gates()), 16'b111110);

        // R11: nested irq ignored, write redirects saved mode
        pulse_irq();
        check("R11 nested mode", 16'(pm_mode), 16'd0);
        check("R11 nested service", 16'(in_service), 16'd1);
        write_mode(3'd2);
        check("R11 write in service", 16'(pm_mode), 16'd0);

        // R10: return restores the redirected mode
        pulse_ret();
        check("R10 restore mode", 16'(pm_mode), 16'd2);
        check("R10 restore service", 16'(in_service), 16'd0);
        pulse_ret();
        check("R10 stray return", 16'(pm_mode), 16'd2);

        // R9: irq together with mode write; write dropped
        @(negedge clk);
        irq = 1'b1;
        mode_wr = 1'b1;
        mode_req = 3'd5;
        @(negedge clk);
        irq = 1'b0;
        mode_wr = 1'b0;
        check("R9 same-cycle write mode", 16'(pm_mode), 16'd0);
        pulse_ret();
        check("R9 same-cycle write restore", 16'(pm_mode), 16'd2);

        // R12: blank vector
        do_reset();
        boot(16'hFFFF);
        check("R12 blank boot mode", 16'(pm_mode), 16'd5);
        @(negedge clk);
        check("R12 blank boot gates", 16'(gates()), 16'b000001);

        // R12: programmed vector, then late blank ignored
        do_reset();
        boot(16'h1234);
        check("R12 programmed boot", 16'(pm_mode), 16'd0);
        boot(16'hFFFF);
        check("R12 late boot ignored", 16'(pm_mode), 16'd0);
        @(negedge clk);
        check("R12 late boot gates", 16'(gates()), 16'b111110);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule